// File: doc/BRIEF.md
# Dual-Compare Pulse Output Generator

This block makes timed pulses from its own up-counting time base and two compare values. The primary value sets the count at which the output goes active. The secondary value sets the count at which it goes inactive again. Both counts are measured from a time base that starts at zero. The block has three live modes: it can emit one pulse and stop, repeat the pulse in every period, or invert the output on each primary match.

The time base has two start modes. In synchronous start it begins to count as soon as a live mode is selected. It wraps after reaching the period value, and it may also be cleared by a pulse from one of several sync sources. In trigger start the counter holds at zero until a trigger arrives. A select bit decides whether that trigger is the hardware input or the software input.

Each compare match gives a one-cycle interrupt pulse. An invert control flips the output polarity. An enabled fault input forces the output to its inactive level at once. It also sets a sticky flag that keeps the output parked until software clears the flag after the fault has gone.

Top module: `pulse_cmp_gen`

## Requirements
- R1: After reset, `out_o` is 0, `match_irq_o` is 0, `fault_flag_o` is 0 and `tmr_o` is 0.
- R2: In synchronous start with `sync_sel_i` = 0, the time base counts up by one each cycle from 0. In the cycle after it equals `period_i`, it reads 0.
- R3: A value k of `sync_sel_i` from 1 to NSRC picks `sync_src_i[k-1]`. A high level on the picked source clears the counter to 0 on the next cycle. Unpicked sources, and values above NSRC, have no effect.
- R4: In continuous mode (`mode_i` = 3'b010), the internal output goes high in the cycle after the count equals `cmp_pri_i`. It goes low in the cycle after the count equals `cmp_sec_i`, in every period. When the two values are equal, the low level wins.
- R5: In single-shot mode (`mode_i` = 3'b001), the output gives one high pulse timed as in R4. After that pulse it stays low until the mode is set to 3'b000.
- R6: In toggle mode (`mode_i` = 3'b011), the output inverts in the cycle after each match of the count with `cmp_pri_i`. The secondary value is ignored.
- R7: In trigger start (`trig_mode_i` = 1), the counter stays at 0 until a trigger arrives, then counts from 0 as in R2. The trigger is `sw_trig_i` when `trig_sw_sel_i` = 1 and `hw_trig_i` when it is 0. The unselected trigger and the sync inputs are ignored.
- R8: With `mode_i` = 3'b000 or any value with bit 2 set, the output is inactive, the counter is 0, and no match is reported.
- R9: `match_irq_o` is high for one cycle, in the cycle after the count matches `cmp_pri_i`. In single-shot and continuous modes it is also high after a match with `cmp_sec_i`.
- R10: `out_o` is the internal output XOR `invert_i`.
- R11: While `fault_en_i` and `fault_i` are both high, `out_o` equals `invert_i`, the inactive level, in the same cycle. While `fault_en_i` is 0, `fault_i` is ignored.
- R12: An enabled fault sets `fault_flag_o` from the next cycle. While the flag is set, `out_o` is held at `invert_i`. The flag clears only on a cycle where `fault_clr_i` is high and the enabled fault is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode: 000 off, 001 single, 010 continuous, 011 toggle |
| cmp_pri_i | input | CNT_W | Count at which the output rises |
| cmp_sec_i | input | CNT_W | Count at which the output falls |
| period_i | input | CNT_W | Last count before the time base wraps |
| trig_mode_i | input | 1 | 1 = trigger start, 0 = synchronous start |
| trig_sw_sel_i | input | 1 | 1 = software trigger, 0 = hardware trigger |
| sw_trig_i | input | 1 | Software trigger |
| hw_trig_i | input | 1 | Hardware trigger |
| sync_sel_i | input | SEL_W | Sync source select, 0 = free running |
| sync_src_i | input | NSRC | Sync source pulses |
| invert_i | input | 1 | Output polarity invert |
| fault_en_i | input | 1 | Fault input enable |
| fault_i | input | 1 | Fault input |
| fault_clr_i | input | 1 | Request to clear the sticky fault flag |
| out_o | output | 1 | Pulse output |
| match_irq_o | output | 1 | One-cycle compare match pulse |
| fault_flag_o | output | 1 | Sticky fault flag |
| tmr_o | output | CNT_W | Current time base count |

## Verification
The bench builds the block with CNT_W = 8, SEL_W = 3 and NSRC = 4. An 8-bit counter makes a period of 255 reachable in a few hundred cycles, so the wrap at the top of the counter range is exercised. A 3-bit select can hold values 5 to 7, which name no source, so the bench can show that such values leave the counter free running.

// File: rtl/pcg_pkg.sv
package pcg_pkg;

  typedef enum logic [2:0] {
    OCM_OFF    = 3'b000,
    OCM_SINGLE = 3'b001,
    OCM_CONT   = 3'b010,
    OCM_TOGGLE = 3'b011
  } ocm_e;

  // A mode is live only with bit 2 clear and a non-zero value.
  function automatic logic mode_live(input logic [2:0] m);
    return (m == OCM_SINGLE) || (m == OCM_CONT) || (m == OCM_TOGGLE);
  endfunction

  // Output level seen on the pin.
  function automatic logic pin_level(input logic oc, input logic inv, input logic hold);
    return hold ? inv : (oc ^ inv);
  endfunction

endpackage

// File: rtl/pcg_timebase.sv
module pcg_timebase #(
  parameter int CNT_W = 16,
  parameter int SEL_W = 5,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             trig_mode_i,
  input  logic             trig_evt_i,
  input  logic [SEL_W-1:0] sync_sel_i,
  input  logic [NSRC-1:0]  sync_src_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             sync_hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] p,
                                                  input logic clr);
    if (clr || c == p) return '0;
    return c + 1'b1;
  endfunction

  always_comb begin
    sync_hit_o = 1'b0;
    if (!trig_mode_i) begin
      for (int i = 0; i < NSRC; i++) begin
        if (sync_sel_i == SEL_W'(i + 1) && sync_src_i[i]) sync_hit_o = 1'b1;
      end
    end
  end

  assign run_o = en_i && (trig_mode_i ? armed_q : 1'b1);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (trig_mode_i && !armed_q) begin
      cnt_q <= '0;
      if (trig_evt_i) armed_q <= 1'b1;
    end else begin
      cnt_q <= next_count(cnt_q, period_i, sync_hit_o);
    end
  end

  // R2
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && !sync_hit_o && cnt_q == period_i) |=> (cnt_q == '0));

  // R3
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && sync_hit_o) |=> (cnt_q == '0));

  // R7
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && trig_mode_i && !armed_q && !trig_evt_i) |=> (cnt_q == '0 && !armed_q));

endmodule

// File: rtl/pcg_compare.sv
module pcg_compare
  import pcg_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] pri_i,
  input  logic [CNT_W-1:0] sec_i,
  output logic             oc_o,
  output logic             irq_o,
  output logic             pri_hit_o,
  output logic             sec_hit_o
);

  logic oc_q, done_q, irq_q, live;

  assign live      = mode_live(mode_i);
  assign pri_hit_o = live && run_i && (cnt_i == pri_i);
  assign sec_hit_o = live && run_i && (cnt_i == sec_i);
  assign oc_o      = oc_q;
  assign irq_o     = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oc_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (!live) begin
      oc_q   <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= pri_hit_o || (sec_hit_o && mode_i != OCM_TOGGLE);
      unique case (mode_i)
        OCM_TOGGLE: if (pri_hit_o) oc_q <= !oc_q;
        OCM_SINGLE: if (!done_q) begin
          if (sec_hit_o) begin
            oc_q <= 1'b0;
            if (oc_q) done_q <= 1'b1;
          end else if (pri_hit_o) oc_q <= 1'b1;
        end
        default: if (sec_hit_o) oc_q <= 1'b0;
                 else if (pri_hit_o) oc_q <= 1'b1;
      endcase
    end
  end

  // R4
  cont_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_CONT && pri_hit_o && !sec_hit_o) |=> oc_q);

  // R5
  single_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_SINGLE && done_q) |=> !oc_q);

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == OCM_TOGGLE && pri_hit_o) |=> (oc_q != $past(oc_q)));

  // R8
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> (!oc_q && !irq_q));

endmodule

// File: rtl/pcg_fault.sv
module pcg_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_en_i,
  input  logic fault_i,
  input  logic fault_clr_i,
  output logic fault_act_o,
  output logic flag_o
);

  logic flag_q;

  assign fault_act_o = fault_en_i && fault_i;
  assign flag_o      = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_q <= 1'b0;
    else if (fault_act_o)                flag_q <= 1'b1;
    else if (fault_clr_i)                flag_q <= 1'b0;
  end

  // R12
  flag_clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> ($past(fault_clr_i) && !$past(fault_act_o)));

endmodule

// File: rtl/pulse_cmp_gen.sv
module pulse_cmp_gen
  import pcg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 5,
  parameter int NSRC  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       mode_i,
  input  logic [CNT_W-1:0] cmp_pri_i,
  input  logic [CNT_W-1:0] cmp_sec_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic             trig_mode_i,
  input  logic             trig_sw_sel_i,
  input  logic             sw_trig_i,
  input  logic             hw_trig_i,
  input  logic [SEL_W-1:0] sync_sel_i,
  input  logic [NSRC-1:0]  sync_src_i,
  input  logic             invert_i,
  input  logic             fault_en_i,
  input  logic             fault_i,
  input  logic             fault_clr_i,
  output logic             out_o,
  output logic             match_irq_o,
  output logic             fault_flag_o,
  output logic [CNT_W-1:0] tmr_o
);

  logic trig_evt, run, sync_hit, oc, pri_hit, sec_hit, fault_act, hold;

  assign trig_evt = trig_sw_sel_i ? sw_trig_i : hw_trig_i;

  pcg_timebase #(.CNT_W(CNT_W), .SEL_W(SEL_W), .NSRC(NSRC)) u_tb (
    .clk, .rst_n,
    .en_i(mode_live(mode_i)), .trig_mode_i, .trig_evt_i(trig_evt),
    .sync_sel_i, .sync_src_i, .period_i,
    .cnt_o(tmr_o), .run_o(run), .sync_hit_o(sync_hit)
  );

  pcg_compare #(.CNT_W(CNT_W)) u_cmp (
    .clk, .rst_n, .mode_i, .run_i(run), .cnt_i(tmr_o),
    .pri_i(cmp_pri_i), .sec_i(cmp_sec_i),
    .oc_o(oc), .irq_o(match_irq_o), .pri_hit_o(pri_hit), .sec_hit_o(sec_hit)
  );

  pcg_fault u_flt (
    .clk, .rst_n, .fault_en_i, .fault_i, .fault_clr_i,
    .fault_act_o(fault_act), .flag_o(fault_flag_o)
  );

  assign hold  = fault_act || fault_flag_o;
  assign out_o = pin_level(oc, invert_i, hold);

  // R11
  fault_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_act |-> (out_o == invert_i));

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq_o |-> $past(pri_hit || sec_hit));

endmodule

// File: tb/pulse_cmp_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_cmp_gen_tb_top;

  localparam int CW = 8;
  localparam int SW = 3;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [CW-1:0] pri = '0, sec = '0, per = '0;
  logic trig_mode = 0, sw_sel = 0, sw_trig = 0, hw_trig = 0;
  logic [SW-1:0] sel = '0;
  logic [NS-1:0] src = '0;
  logic inv = 0, f_en = 0, f_in = 0, f_clr = 0;
  logic out, irq, flag;
  logic [CW-1:0] tmr;

  always #2 clk = ~clk;

  pulse_cmp_gen #(.CNT_W(CW), .SEL_W(SW), .NSRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .cmp_pri_i(pri), .cmp_sec_i(sec),
    .period_i(per), .trig_mode_i(trig_mode), .trig_sw_sel_i(sw_sel),
    .sw_trig_i(sw_trig), .hw_trig_i(hw_trig), .sync_sel_i(sel), .sync_src_i(src),
    .invert_i(inv), .fault_en_i(f_en), .fault_i(f_in), .fault_clr_i(f_clr),
    .out_o(out), .match_irq_o(irq), .fault_flag_o(flag), .tmr_o(tmr)
  );

  int checks = 0, errors = 0, rises = 0;
  string cur_req = "R1";
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
    end
  endtask

  typedef struct packed {
    logic [CW-1:0] cnt;
    logic oc;
    logic irq;
    logic flag;
  } exp_t;
  exp_t q[$];

  // Reference state built from the requirements
  logic [CW-1:0] m_cnt = '0;
  logic m_arm = 0, m_oc = 0, m_done = 0, m_irq = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_arm = 0; m_oc = 0; m_done = 0; m_irq = 0; m_flag = 0;
    end else begin
      bit live, run, ph, sh, sy, tev, fa;
      exp_t e;
      live = (mode == 3'b001) || (mode == 3'b010) || (mode == 3'b011);
      run  = live && (trig_mode ? m_arm : 1'b1);
      ph   = run && (m_cnt == pri);
      sh   = run && (m_cnt == sec);
      sy   = !trig_mode && sel != 0 && int'(sel) <= NS && src[int'(sel) - 1];
      tev  = sw_sel ? sw_trig : hw_trig;
      fa   = f_en && f_in;
      if (fa) m_flag = 1; else if (f_clr) m_flag = 0;
      if (!live) begin
        m_oc = 0; m_done = 0; m_irq = 0;
      end else begin
        m_irq = ph || (sh && mode != 3'b011);
        if (mode == 3'b011) begin
          if (ph) m_oc = !m_oc;
        end else if (mode == 3'b001) begin
          if (!m_done) begin
            if (sh) begin if (m_oc) m_done = 1; m_oc = 0; end
            else if (ph) m_oc = 1;
          end
        end else begin
          if (sh) m_oc = 0; else if (ph) m_oc = 1;
        end
      end
      if (!live) begin m_cnt = '0; m_arm = 0; end
      else if (trig_mode && !m_arm) begin m_cnt = '0; if (tev) m_arm = 1; end
      else if (sy || m_cnt == per) m_cnt = '0;
      else m_cnt = m_cnt + 1'b1;
      e.cnt = m_cnt; e.oc = m_oc; e.irq = m_irq; e.flag = m_flag;
      q.push_back(e);
    end
  end

  logic prev_out = 0;
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      bit eo;
      e = q.pop_front();
      eo = ((f_en && f_in) || e.flag) ? inv : (e.oc ^ inv);
      chk(tmr == e.cnt, {cur_req, " count"}, int'(tmr), int'(e.cnt));
      chk(irq == e.irq, {cur_req, " R9 irq"}, int'(irq), int'(e.irq));
      chk(flag == e.flag, {cur_req, " R12 flag"}, int'(flag), int'(e.flag));
      chk(out == eo, {cur_req, " R10/R11 out"}, int'(out), int'(eo));
      if (out && !prev_out) rises++;
      prev_out = out;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go_off();
    mode = 3'b000; trig_mode = 0; sel = '0; src = '0; inv = 0;
    cyc(2);
  endtask

  initial begin
    #3;
    chk(out == 0 && irq == 0 && flag == 0, "R1 outputs", int'({out, irq, flag}), 0);
    chk(tmr == 0, "R1 count", int'(tmr), 0);
    cyc(2);
    rst_n = 1;
    cyc(1);

    cur_req = "R2/R4"; pri = 3; sec = 7; per = 9; mode = 3'b010;
    cyc(40);
    cur_req = "R4 equal"; go_off(); pri = 5; sec = 5; mode = 3'b010;
    cyc(20);
    cur_req = "R2 top"; go_off(); pri = 250; sec = 255; per = 255; mode = 3'b010;
    cyc(300);

    cur_req = "R3"; go_off(); pri = 2; sec = 6; per = 20; sel = 2; mode = 3'b010;
    cyc(8); src = 4'b0001; cyc(1); src = 4'b0000; cyc(3);
    src = 4'b0010; cyc(1); src = 4'b0000; cyc(10);
    sel = 6; src = 4'b1111; cyc(25); src = '0;

    cur_req = "R5"; go_off(); pri = 2; sec = 4; per = 7; rises = 0; mode = 3'b001;
    cyc(40);
    chk(rises == 1, "R5 one pulse", rises, 1);
    cur_req = "R5 rearm"; go_off(); rises = 0; mode = 3'b001;
    cyc(12);
    chk(rises == 1, "R5 rearm pulse", rises, 1);

    cur_req = "R6"; go_off(); pri = 1; sec = 3; per = 5; rises = 0; mode = 3'b011;
    cyc(36);
    chk(rises == 3, "R6 toggles", rises, 3);

    cur_req = "R7 sw"; go_off(); pri = 2; sec = 5; per = 8; trig_mode = 1; sw_sel = 1;
    sel = 1; mode = 3'b010;
    cyc(4); hw_trig = 1; src = 4'b0001; cyc(1); hw_trig = 0; src = '0; cyc(4);
    chk(tmr == 0, "R7 hold", int'(tmr), 0);
    sw_trig = 1; cyc(1); sw_trig = 0; cyc(30);
    cur_req = "R7 hw"; mode = 3'b000; cyc(2); sw_sel = 0; mode = 3'b010;
    cyc(3); sw_trig = 1; cyc(1); sw_trig = 0; cyc(3);
    chk(tmr == 0, "R7 sw ignored", int'(tmr), 0);
    hw_trig = 1; cyc(1); hw_trig = 0; cyc(20);

    cur_req = "R10"; go_off(); trig_mode = 0; pri = 1; sec = 4; per = 6; inv = 1; mode = 3'b010;
    cyc(20);

    cur_req = "R11/R12"; f_en = 1; f_in = 1; cyc(3);
    chk(out == inv, "R11 parked", int'(out), int'(inv));
    f_clr = 1; cyc(1); f_clr = 0;
    chk(flag == 1, "R12 clear blocked", int'(flag), 1);
    f_in = 0; cyc(5);
    chk(flag == 1, "R12 sticky", int'(flag), 1);
    f_clr = 1; cyc(1); f_clr = 0; cyc(10);
    chk(flag == 0, "R12 cleared", int'(flag), 0);
    f_en = 0; f_in = 1; cyc(15); f_in = 0;

    cur_req = "R8"; inv = 0; mode = 3'b110; cyc(10);
    chk(tmr == 0 && out == 0, "R8 idle", int'(tmr), 0);
    mode = 3'b000; cyc(5);

    cyc(2);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule